// File: doc/BRIEF.md
# Floating-Point Compare and Exception Unit

This block holds the floating-point status word of a processor core. It turns compare results and arithmetic exception flags into status updates and trap requests. An external comparator reports the relation of two operands as equal, less, greater or unordered. The block writes the matching two-bit condition code into one of four condition-code fields, chosen by a select input.

An external arithmetic unit reports the five IEEE exception flags of each operation. The block copies them into the current-exception field and tests them against the trap-enable mask. It then either raises a one-cycle trap pulse or merges the flags into the accrued-exception field.

A signaling compare traps on an unordered result whether or not the invalid enable is set. Software can load the whole status word through a write port. The rounding-direction field is decoded into a one-hot selector for the arithmetic unit.

Top module: `fp_cmp_status`

## Requirements
- R1: While `rstN` is low, `status` is all zeros and `trapPulse` is 0.
- R2: A cycle with `wrEn` high loads `status` with `wrData` at the next clock edge. Any compare or flag strobe in that same cycle is ignored and raises no trap.
- R3: A compare (`cmpValid`, no write) first clears the field selected by `ccSel` and then writes `cmpRel` into it. The codes are 00 equal, 01 less, 10 greater and 11 unordered. The fields sit at bits 11:10 for select 0, 33:32 for 1, 35:34 for 2 and 37:36 for 3. The three other fields are left unchanged.
- R4: An unordered compare traps when `cmpSignal` is high or the invalid trap-enable bit 27 is set. A trap pulses `trapPulse` for the next cycle, sets current-invalid bit 4 and sets the trap-type field 16:14 to 001. It leaves the accrued field 9:5 unchanged.
- R5: An unordered compare that does not trap sets accrued-invalid bit 9. It leaves bits 4:0 and 16:14 unchanged and raises no trap pulse.
- R6: A flag strobe (`flagValid`, no write, no compare) replaces current-exception bits 4:0 with `ieeeFlags`. The flag order is bit 4 invalid, 3 overflow, 2 underflow, 1 divide-by-zero and 0 inexact.
- R7: If `ieeeFlags` ANDed with the trap-enable bits 27:23 (same bit order) is nonzero, the flag strobe traps. It sets trap type 16:14 to 001, pulses `trapPulse` and leaves the accrued bits 9:5 unchanged.
- R8: A flag strobe that does not trap ORs `ieeeFlags` into accrued bits 9:5 and leaves bits 16:14 unchanged.
- R9: A compare and a flag strobe in the same cycle apply the compare only. The flags are discarded.
- R10: `roundSel` is one-hot from rounding field 31:30. Bit 0 means nearest-even (00), bit 1 toward zero (01), bit 2 toward +infinity (10) and bit 3 toward -infinity (11).
- R11: `trapPulse` is high for exactly one cycle per trapping event. It rises on the same clock edge that writes the status update of that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Load the whole status word |
| wrData | input | 38 | Status word to load |
| cmpValid | input | 1 | Compare result strobe |
| cmpRel | input | 2 | Relation: 00 eq, 01 lt, 10 gt, 11 unordered |
| ccSel | input | 2 | Condition-code field select |
| cmpSignal | input | 1 | Compare is of the signaling kind |
| flagValid | input | 1 | IEEE flag strobe |
| ieeeFlags | input | 5 | Invalid, overflow, underflow, div-by-zero, inexact |
| status | output | 38 | Status word |
| trapPulse | output | 1 | One-cycle trap request |
| roundSel | output | 4 | One-hot rounding direction |

## Verification
A compare strobe and a flag strobe can arrive in the same cycle, and a status write can coincide with either. The bench provokes these collisions in directed steps. It pairs an ordered compare with flags that would have trapped, and a write with a signaling unordered compare. The random phase then sets each strobe on about half of the cycles, so every overlap recurs often. A reference model drops the lower-priority strobe. The bench judges each collision from the full status word and the trap pulse one cycle later.

// File: rtl/fpcu_pkg.sv
package fpcu_pkg;
  parameter int STAT_W    = 38;
  parameter int EXC_W     = 5;
  parameter int CUR_LO    = 0;
  parameter int ACC_LO    = CUR_LO + 5;
  parameter int TEM_LO    = CUR_LO + 23;
  parameter int TT_LO     = 14;
  parameter int TT_W      = 3;
  parameter int RND_LO    = 30;
  parameter int RND_W     = 2;
  parameter int CC_W      = 2;
  parameter int CC_NUM    = 4;
  parameter int CC_SEL_W  = $clog2(CC_NUM);
  parameter int CC0_LO    = 10;
  parameter int CC_EXT_LO = 32;
  parameter int INV_BIT   = 4;
  parameter logic [TT_W-1:0] TT_IEEE = 3'd1;

  typedef enum logic [CC_W-1:0] {
    REL_EQ = 2'b00,
    REL_LT = 2'b01,
    REL_GT = 2'b10,
    REL_UN = 2'b11
  } rel_e;

  typedef struct packed {
    logic doWrite;
    logic doCompare;
    logic doFlags;
    logic trapTake;
    logic accumOn;
  } ctl_t;

  function automatic int ccLow(input int idx);
    return (idx == 0) ? CC0_LO : CC_EXT_LO + CC_W * (idx - 1);
  endfunction
endpackage

// File: rtl/fpcu_ctrl.sv
module fpcu_ctrl
  import fpcu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             cmpValid,
  input  logic [CC_W-1:0]  cmpRel,
  input  logic             cmpSignal,
  input  logic             flagValid,
  input  logic [EXC_W-1:0] ieeeFlags,
  input  logic [EXC_W-1:0] trapEn,
  output ctl_t             ctl,
  output logic             trapPulse
);
  logic unordered;
  logic cmpTrap;
  logic flagTrap;

  always_comb begin
    ctl.doWrite   = wrEn;
    ctl.doCompare = cmpValid && !wrEn;
    ctl.doFlags   = flagValid && !wrEn && !cmpValid;
    unordered     = (cmpRel == REL_UN);
    cmpTrap       = ctl.doCompare && unordered && (cmpSignal || trapEn[INV_BIT]);
    flagTrap      = ctl.doFlags && (|(ieeeFlags & trapEn));
    ctl.trapTake  = cmpTrap || flagTrap;
    ctl.accumOn   = (ctl.doCompare && unordered && !cmpTrap) ||
                    (ctl.doFlags && !flagTrap);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trapPulse <= 1'b0;
    else       trapPulse <= ctl.trapTake;
  end

  // R2: a write masks any trap in its cycle
  a_r2_write_no_trap: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !trapPulse);

  // R4: signaling unordered compare always traps
  a_r4_signal_trap: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && !wrEn && cmpRel == REL_UN && cmpSignal) |=> trapPulse);
endmodule

// File: rtl/fpcu_dp.sv
module fpcu_dp
  import fpcu_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctl_t                ctl,
  input  logic [STAT_W-1:0]   wrData,
  input  logic [CC_W-1:0]     cmpRel,
  input  logic [CC_SEL_W-1:0] ccSel,
  input  logic [EXC_W-1:0]    ieeeFlags,
  output logic [STAT_W-1:0]   stat,
  output logic [3:0]          roundSel
);
  localparam int RND_NUM = 1 << RND_W;

  logic [CC_NUM-1:0][STAT_W-1:0] ccMask;
  logic [CC_NUM-1:0][STAT_W-1:0] ccPlaced;
  logic [STAT_W-1:0]             nxt;
  logic [EXC_W-1:0]              accBits;

  for (genvar g = 0; g < CC_NUM; g++) begin : gCcField
    localparam int LO = ccLow(g);
    assign ccMask[g]   = {{(STAT_W-CC_W){1'b0}}, {CC_W{1'b1}}} << LO;
    assign ccPlaced[g] = {{(STAT_W-CC_W){1'b0}}, cmpRel} << LO;

    // R3: selected field takes the relation code
    a_r3_field_written: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.doCompare && ccSel == CC_SEL_W'(g)) |=> (stat[LO +: CC_W] == $past(cmpRel)));
    // R3: unselected fields keep their value
    a_r3_field_kept: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.doCompare && ccSel != CC_SEL_W'(g)) |=> $stable(stat[LO +: CC_W]));
  end

  for (genvar r = 0; r < RND_NUM; r++) begin : gRound
    assign roundSel[r] = (stat[RND_LO +: RND_W] == RND_W'(r));
  end

  always_comb begin
    accBits = ctl.doCompare ? (EXC_W'(1) << INV_BIT) : ieeeFlags;
    nxt     = stat;
    if (ctl.doWrite) begin
      nxt = wrData;
    end else begin
      if (ctl.doCompare) begin
        nxt = (nxt & ~ccMask[ccSel]) | ccPlaced[ccSel];
        if (ctl.trapTake) nxt[CUR_LO + INV_BIT] = 1'b1;
      end
      if (ctl.doFlags)  nxt[CUR_LO +: EXC_W] = ieeeFlags;
      if (ctl.trapTake) nxt[TT_LO +: TT_W]   = TT_IEEE;
      if (ctl.accumOn)  nxt[ACC_LO +: EXC_W] = stat[ACC_LO +: EXC_W] | accBits;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stat <= '0;
    else       stat <= nxt;
  end

  // R2: write loads the whole word
  a_r2_write_load: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doWrite |=> (stat == $past(wrData)));
  // R4 / R7: trap marks trap type
  a_r7_trap_type: assert property (@(posedge clk) disable iff (!rstN)
    ctl.trapTake |=> (stat[TT_LO +: TT_W] == TT_IEEE));
  // R4 / R7: accrued field is held on a trap
  a_r7_acc_hold: assert property (@(posedge clk) disable iff (!rstN)
    ctl.trapTake |=> $stable(stat[ACC_LO +: EXC_W]));
  // R8: accrued bits never drop without a write
  a_r8_acc_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.doWrite |=> ((stat[ACC_LO +: EXC_W] & $past(stat[ACC_LO +: EXC_W])) ==
                      $past(stat[ACC_LO +: EXC_W])));
endmodule

// File: rtl/fp_cmp_status.sv
module fp_cmp_status
  import fpcu_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [STAT_W-1:0]   wrData,
  input  logic                cmpValid,
  input  logic [CC_W-1:0]     cmpRel,
  input  logic [CC_SEL_W-1:0] ccSel,
  input  logic                cmpSignal,
  input  logic                flagValid,
  input  logic [EXC_W-1:0]    ieeeFlags,
  output logic [STAT_W-1:0]   status,
  output logic                trapPulse,
  output logic [3:0]          roundSel
);
  ctl_t ctl;

  fpcu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .cmpValid  (cmpValid),
    .cmpRel    (cmpRel),
    .cmpSignal (cmpSignal),
    .flagValid (flagValid),
    .ieeeFlags (ieeeFlags),
    .trapEn    (status[TEM_LO +: EXC_W]),
    .ctl       (ctl),
    .trapPulse (trapPulse)
  );

  fpcu_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .wrData    (wrData),
    .cmpRel    (cmpRel),
    .ccSel     (ccSel),
    .ieeeFlags (ieeeFlags),
    .stat      (status),
    .roundSel  (roundSel)
  );

  // R9: compare beats flags, current field kept on an ordered compare
  a_r9_flags_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && flagValid && !wrEn && cmpRel != REL_UN) |=>
      $stable(status[CUR_LO +: EXC_W]));
  // R11: a trap pulse always comes with the IEEE trap type
  a_r11_pulse_type: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> (status[TT_LO +: TT_W] == TT_IEEE));
  // R10: rounding selector is one-hot
  a_r10_round_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $countones(roundSel) == 1);
endmodule

// File: tb/test_fp_cmp_status.sv
`timescale 1ns/1ps
module test_fp_cmp_status;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [37:0] wrData;
  logic        cmpValid;
  logic [1:0]  cmpRel;
  logic [1:0]  ccSel;
  logic        cmpSignal;
  logic        flagValid;
  logic [4:0]  ieeeFlags;
  logic [37:0] status;
  logic        trapPulse;
  logic [3:0]  roundSel;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [37:0] expS;
  logic        expTrap;

  always #5 clk = ~clk;

  fp_cmp_status i_fp_cmp_status (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .cmpValid(cmpValid), .cmpRel(cmpRel), .ccSel(ccSel), .cmpSignal(cmpSignal),
    .flagValid(flagValid), .ieeeFlags(ieeeFlags),
    .status(status), .trapPulse(trapPulse), .roundSel(roundSel)
  );

  function automatic int ccOff(input logic [1:0] sel);
    return (sel == 2'd0) ? 10 : 30 + 2 * int'(sel);
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic modelStep(input logic we, input logic [37:0] wd, input logic cv,
                           input logic [1:0] rel, input logic [1:0] sel, input logic sig,
                           input logic fv, input logic [4:0] fl);
    int off;
    expTrap = 1'b0;
    if (we) begin
      expS = wd;
    end else if (cv) begin
      off = ccOff(sel);
      expS[off +: 2] = 2'b00;
      expS[off +: 2] = rel;
      if (rel == 2'b11) begin
        if (sig || expS[27]) begin
          expS[4] = 1'b1;
          expS[16:14] = 3'b001;
          expTrap = 1'b1;
        end else begin
          expS[9] = 1'b1;
        end
      end
    end else if (fv) begin
      expS[4:0] = fl;
      if ((fl & expS[27:23]) != 5'd0) begin
        expS[16:14] = 3'b001;
        expTrap = 1'b1;
      end else begin
        expS[9:5] = expS[9:5] | fl;
      end
    end
  endtask

  task automatic idleInputs();
    wrEn = 0; wrData = '0; cmpValid = 0; cmpRel = 0; ccSel = 0;
    cmpSignal = 0; flagValid = 0; ieeeFlags = 0;
  endtask

  task automatic step(input string tag, input logic we, input logic [37:0] wd,
                      input logic cv, input logic [1:0] rel, input logic [1:0] sel,
                      input logic sig, input logic fv, input logic [4:0] fl);
    wrEn = we; wrData = wd; cmpValid = cv; cmpRel = rel; ccSel = sel;
    cmpSignal = sig; flagValid = fv; ieeeFlags = fl;
    modelStep(we, wd, cv, rel, sel, sig, fv, fl);
    @(posedge clk);
    @(negedge clk);
    idleInputs();
    chk(tag, "status", 64'(status), 64'(expS));
    chk(tag, "trapPulse", 64'(trapPulse), 64'(expTrap));
    chk({tag, " R10"}, "roundSel", 64'(roundSel), 64'(4'b0001 << expS[31:30]));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd7019);
    idleInputs();
    rstN = 1'b0;
    expS = '0;
    repeat (3) @(negedge clk);
    chk("R1", "status in reset", 64'(status), 64'd0);
    chk("R1", "trapPulse in reset", 64'(trapPulse), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "status after reset", 64'(status), 64'd0);

    // R2 + R10: load word with round toward zero
    step("R2", 1, 38'h0_4000_0000, 0, 0, 0, 0, 0, 0);
    step("R10", 1, 38'h0_C000_0000, 0, 0, 0, 0, 0, 0);
    step("R10", 1, 38'h0_8000_0000, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 38'h0, 0, 0, 0, 0, 0, 0);
    // R3: every field, every ordered code
    for (int s = 0; s < 4; s++)
      for (int r = 0; r < 3; r++)
        step("R3", 0, '0, 1, 2'(r), 2'(s), 0, 0, 0);
    step("R3", 0, '0, 1, 2'b01, 2'd2, 0, 0, 0);
    // R5: quiet unordered, invalid not enabled
    step("R5", 0, '0, 1, 2'b11, 2'd1, 0, 0, 0);
    // R4: signaling unordered
    step("R4", 0, '0, 1, 2'b11, 2'd3, 1, 0, 0);
    step("R11", 0, '0, 0, 0, 0, 0, 0, 0);
    // R4: invalid enable set, quiet unordered
    step("R4", 1, 38'h0_0800_0000, 0, 0, 0, 0, 0, 0);
    step("R4", 0, '0, 1, 2'b11, 2'd0, 0, 0, 0);
    // R6 / R8: flags with overflow enable only
    step("R8", 1, 38'h0_0400_0000, 0, 0, 0, 0, 0, 0);
    step("R6", 0, '0, 0, 0, 0, 0, 1, 5'b00101);
    step("R8", 0, '0, 0, 0, 0, 0, 1, 5'b00010);
    // R7: overflow enabled and raised
    step("R7", 0, '0, 0, 0, 0, 0, 1, 5'b01001);
    step("R11", 0, '0, 0, 0, 0, 0, 0, 0);
    // R9: compare with trapping flags in the same cycle
    step("R9", 0, '0, 1, 2'b10, 2'd1, 0, 1, 5'b01000);
    // R2: write with signaling unordered compare
    step("R2", 1, 38'h2_5000_0000, 1, 2'b11, 2'd0, 1, 1, 5'b11111);

    for (int i = 0; i < 600; i++) begin
      logic we;
      logic [37:0] wd;
      we = ($urandom % 8) == 0;
      wd = {$urandom, $urandom};
      step("R2 R3 R4 R5 R6 R7 R8 R9 R11", we, wd, 1'($urandom), 2'($urandom),
           2'($urandom), 1'($urandom % 4 == 0), 1'($urandom), 5'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule